// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the arithmetic core of a small accumulator-based processor datapath. It is purely combinational. An operation code selects the operation. The block reads two accumulator values, a memory operand and the current condition flags. It returns an 8-bit result together with updated half-carry, negative, zero, overflow and carry flags.

The multiply operation returns a 16-bit product split into a high byte and a low byte. The high byte goes to the first accumulator and the low byte to the second. The surrounding pipeline is responsible for:
- decoding the addressing mode;
- fetching the memory operand;
- writing the result and the flags back.

Top module: `alu8_core`

## Requirements
- R1: The `flags_in` and `flags_out` bit positions are: bit 0 carry (C), bit 1 overflow (V), bit 2 zero (Z), bit 3 negative (N), bit 4 half carry (H). The `op_sel` codes are:
  - 0: A+M
  - 1: A+M+C
  - 2: A−M
  - 3: A−M−C
  - 4: B+M
  - 5: B+M+C
  - 6: B−M
  - 7: B−M−C
  - 8: A+B
  - 9: A−B
  - 10: 0−A
  - 11: 0−B
  - 12: 0−M
  - 13: A×B

  For codes 0 to 12, `res_lo` is the result modulo 256 and `res_hi` is 0.
- R2: For codes 0 to 12, Z is 1 exactly when `res_lo` is zero.
- R3: For codes 0 to 12, N equals bit 7 of `res_lo`.
- R4: For codes 0 to 9, C is 1 when the exact unsigned result, including any carry-in or borrow-in taken from input C, is above 255 or below 0.
- R5: For codes 0 to 9, V is 1 when the exact signed result lies outside −128..127.
- R6: For codes 0, 1, 4, 5 and 8, H is the carry from bit 3 into bit 4, including the carry-in. For every other code, H equals the input H.
- R7: For codes 10 to 12, `res_lo` is the two's complement of the operand. V is 1 only for operand 0x80, and C is 1 when the operand is nonzero.
- R8: For code 13, {`res_hi`,`res_lo`} is the unsigned product A×B and C equals bit 7 of the product. N, Z, V and H keep their input values.
- R9: For codes 14 and 15, `res_hi` and `res_lo` are 0 and `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| acc_a | input | 8 | Accumulator A value |
| acc_b | input | 8 | Accumulator B value |
| mem_opd | input | 8 | Memory operand |
| flags_in | input | 5 | Current flags {H,N,Z,V,C} |
| res_hi | output | 8 | Product high byte (0 unless multiply) |
| res_lo | output | 8 | Result, or product low byte |
| flags_out | output | 5 | Updated flags {H,N,Z,V,C} |

## Verification
Several checks run on every evaluation:
- For the negate codes, the carry and overflow outputs must match the shape of the result.
- For multiply and the unused codes, the flag bits that should hold their values must pass through unchanged.
- H must be kept on every non-add code.
- The high byte must stay zero outside multiply.
- Unsigned wrap on plain addition must match the carry.

The bench's scenarios are needed for the rest. These are the exact carry and borrow values with a carry-in, signed overflow on subtract-with-borrow, and half-carry values. The full product value also needs them. The bench compares all of these against a reference built on integers, over directed corners and random operands for every code.

// File: rtl/alu8_pkg.sv
// Shared types for the 8-bit accumulator ALU.
// Assumes op codes are 4 bits wide; codes 14 and 15 are unused.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADDA = 4'd0,  OP_ADCA = 4'd1,  OP_SUBA = 4'd2,  OP_SBCA = 4'd3,
        OP_ADDB = 4'd4,  OP_ADCB = 4'd5,  OP_SUBB = 4'd6,  OP_SBCB = 4'd7,
        OP_ABA  = 4'd8,  OP_SBA  = 4'd9,  OP_NEGA = 4'd10, OP_NEGB = 4'd11,
        OP_NEGM = 4'd12, OP_MUL  = 4'd13
    } alu_op_e;

    typedef enum logic [2:0] {
        K_ADD, K_SUB, K_NEG, K_MUL, K_NONE
    } alu_kind_e;

    // Flag word: bit4 H, bit3 N, bit2 Z, bit1 V, bit0 C
    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/alu8_decode.sv
// Operand decoder: maps the op code to the two adder operands, the
// carry/borrow-in and the operation class. Assumes the negate operand
// is subtracted from zero by the shared adder.
module alu8_decode
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] m,
    input  logic          cin,
    output logic [DW-1:0] x,
    output logic [DW-1:0] y,
    output logic          ci,
    output alu_kind_e     kind
);

    // Select operands and class per op code
    always_comb begin
        x    = a;
        y    = m;
        ci   = 1'b0;
        kind = K_NONE;
        case (alu_op_e'(op))
            OP_ADDA: kind = K_ADD;
            OP_ADCA: begin kind = K_ADD; ci = cin; end
            OP_SUBA: kind = K_SUB;
            OP_SBCA: begin kind = K_SUB; ci = cin; end
            OP_ADDB: begin kind = K_ADD; x = b; end
            OP_ADCB: begin kind = K_ADD; x = b; ci = cin; end
            OP_SUBB: begin kind = K_SUB; x = b; end
            OP_SBCB: begin kind = K_SUB; x = b; ci = cin; end
            OP_ABA:  begin kind = K_ADD; y = b; end
            OP_SBA:  begin kind = K_SUB; y = b; end
            OP_NEGA: begin kind = K_NEG; x = '0; y = a; end
            OP_NEGB: begin kind = K_NEG; x = '0; y = b; end
            OP_NEGM: begin kind = K_NEG; x = '0; y = m; end
            OP_MUL:  kind = K_MUL;
            default: kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/alu8_addsub.sv
// Shared adder/subtractor. In subtract mode it forms x - y - ci as
// x + ~y + ~ci. It reports a borrow as carry-out, signed overflow from
// the effective operand signs, and the carry out of the lower half.
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          ci,
    input  logic          sub,
    output logic [DW-1:0] r,
    output logic          c,
    output logic          v,
    output logic          h
);

    localparam int HB = DW / 2;

    logic [DW-1:0] y_eff;
    logic          ci_eff;
    logic [DW:0]   sum;
    logic [HB:0]   lsum;

    // Invert operand and carry for subtraction, then add
    always_comb begin
        y_eff  = sub ? ~y : y;
        ci_eff = sub ? ~ci : ci;
        sum    = {1'b0, x} + {1'b0, y_eff} + {{DW{1'b0}}, ci_eff};
        lsum   = {1'b0, x[HB-1:0]} + {1'b0, y_eff[HB-1:0]} + {{HB{1'b0}}, ci_eff};
        r      = sum[DW-1:0];
        c      = sum[DW] ^ sub;
        v      = (x[DW-1] == y_eff[DW-1]) && (sum[DW-1] != x[DW-1]);
        h      = lsum[HB];
    end

endmodule

// File: rtl/alu8_mul.sv
// Unsigned DW x DW multiplier producing a 2*DW-bit product.
module alu8_mul #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] prod
);

    // Zero-extend both operands and multiply
    always_comb begin
        prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    end

endmodule

// File: rtl/alu8_core.sv
// Combinational accumulator ALU top. It decodes the op, runs the shared
// adder or the multiplier, and merges the new flags with the flags that
// pass through. Assumes flags_in bit 0 (C) is the carry/borrow-in.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] acc_a,
    input  logic [DW-1:0] acc_b,
    input  logic [DW-1:0] mem_opd,
    input  logic [4:0]    flags_in,
    output logic [DW-1:0] res_hi,
    output logic [DW-1:0] res_lo,
    output logic [4:0]    flags_out
);

    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] SIGN_MIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] opx, opy, sum_r;
    logic          op_ci, sum_c, sum_v, sum_h, is_sub;
    alu_kind_e     kind;
    logic [PW-1:0] prod;
    ccr_t          fi, fo;

    assign fi = ccr_t'(flags_in);

    alu8_decode #(.DW(DW)) u_decode (
        .op(op_sel), .a(acc_a), .b(acc_b), .m(mem_opd), .cin(fi.c),
        .x(opx), .y(opy), .ci(op_ci), .kind(kind)
    );

    assign is_sub = (kind == K_SUB) || (kind == K_NEG);

    alu8_addsub #(.DW(DW)) u_addsub (
        .x(opx), .y(opy), .ci(op_ci), .sub(is_sub),
        .r(sum_r), .c(sum_c), .v(sum_v), .h(sum_h)
    );

    alu8_mul #(.DW(DW)) u_mul (
        .a(acc_a), .b(acc_b), .prod(prod)
    );

    // Merge results and flags per operation class
    always_comb begin
        fo     = fi;
        res_hi = '0;
        res_lo = '0;
        case (kind)
            K_ADD, K_SUB, K_NEG: begin
                res_lo = sum_r;
                fo.n   = sum_r[DW-1];
                fo.z   = (sum_r == '0);
                fo.v   = sum_v;
                fo.c   = sum_c;
                if (kind == K_ADD) fo.h = sum_h;
            end
            K_MUL: begin
                res_hi = prod[PW-1:DW];
                res_lo = prod[DW-1:0];
                fo.c   = prod[DW-1];
            end
            default: ;
        endcase
    end

    assign flags_out = fo;

    // Cross-checks between the ports on every evaluation
    always_comb begin
        if (op_sel >= 4'd10 && op_sel <= 4'd12) begin
            // R7
            neg_carry_chk: assert (flags_out[0] == (res_lo != '0))
                else $error("R7 negate carry mismatch");
            // R7
            neg_ovf_chk: assert (flags_out[1] == (res_lo == SIGN_MIN))
                else $error("R7 negate overflow mismatch");
        end
        if (op_sel == 4'd13) begin
            // R8
            mul_hold_chk: assert (flags_out[4:1] == flags_in[4:1])
                else $error("R8 multiply changed held flags");
        end
        if (op_sel >= 4'd14) begin
            // R9
            unused_pass_chk: assert (flags_out == flags_in && res_lo == '0 && res_hi == '0)
                else $error("R9 unused op not inert");
        end
        if (op_sel != 4'd13) begin
            // R1
            hi_zero_chk: assert (res_hi == '0)
                else $error("R1 high byte nonzero");
        end
        if (op_sel == 4'd2 || op_sel == 4'd3 || op_sel == 4'd6 || op_sel == 4'd7 ||
            op_sel >= 4'd9) begin
            // R6
            h_hold_chk: assert (flags_out[4] == flags_in[4])
                else $error("R6 half carry changed on non-add");
        end
        if (op_sel == 4'd0) begin
            // R4
            add_wrap_chk: assert (flags_out[0] == (res_lo < acc_a))
                else $error("R4 add carry vs wrap mismatch");
        end
    end

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;

    logic       clk = 1'b0;
    logic [3:0] op  = '0;
    logic [7:0] a   = '0;
    logic [7:0] b   = '0;
    logic [7:0] m   = '0;
    logic [4:0] fi  = '0;
    logic [7:0] hi, lo;
    logic [4:0] fo;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu8_core u_alu8_core (
        .op_sel(op), .acc_a(a), .acc_b(b), .mem_opd(m), .flags_in(fi),
        .res_hi(hi), .res_lo(lo), .flags_out(fo)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (op %0d a %0h b %0h m %0h f %0h)",
                     tag, what, act, exp, op, a, b, m, fi);
        end
    endtask

    // Behavioural reference: integer arithmetic per operation
    task automatic model(input int o, input int va, input int vb, input int vm, input int f,
                         output int ehi, output int elo, output int ef, output int kind);
        int x, y, ci, d, sx, sy, sd, h, c, v, z, n, p;
        x = 0; y = 0; ci = 0; kind = 4;
        h = (f >> 4) & 1; n = (f >> 3) & 1; z = (f >> 2) & 1; v = (f >> 1) & 1; c = f & 1;
        ehi = 0; elo = 0;
        if (o <= 9) begin
            x    = (o >= 4 && o <= 7) ? vb : va;
            y    = (o >= 8) ? vb : vm;
            ci   = (o == 1 || o == 3 || o == 5 || o == 7) ? c : 0;
            kind = (o == 0 || o == 1 || o == 4 || o == 5 || o == 8) ? 0 : 1;
        end else if (o <= 12) begin
            x = 0; y = (o == 10) ? va : (o == 11) ? vb : vm; kind = 2;
        end else if (o == 13) begin
            kind = 3;
        end
        if (kind <= 2) begin
            sx = (x > 127) ? x - 256 : x;
            sy = (y > 127) ? y - 256 : y;
            if (kind == 0) begin
                d = x + y + ci; sd = sx + sy + ci;
                h = (((x & 15) + (y & 15) + ci) > 15) ? 1 : 0;
            end else begin
                d = x - y - ci; sd = sx - sy - ci;
            end
            elo = d & 255;
            c = (d < 0 || d > 255) ? 1 : 0;
            v = (sd > 127 || sd < -128) ? 1 : 0;
            z = (elo == 0) ? 1 : 0;
            n = (elo >= 128) ? 1 : 0;
        end else if (kind == 3) begin
            p = va * vb; ehi = p >> 8; elo = p & 255; c = (p >> 7) & 1;
        end
        ef = (h << 4) | (n << 3) | (z << 2) | (v << 1) | c;
    endtask

    task automatic run(input int o, input int va, input int vb, input int vm, input int f);
        int ehi, elo, ef, kind;
        string tr, tc, tv, tz, tn, th;
        @(posedge clk);
        #1;
        op = 4'(o); a = 8'(va); b = 8'(vb); m = 8'(vm); fi = 5'(f);
        model(o, va, vb, vm, f, ehi, elo, ef, kind);
        tr = "R1"; tc = "R4"; tv = "R5"; tz = "R2"; tn = "R3"; th = "R6";
        if (kind == 2) begin tr = "R7"; tc = "R7"; tv = "R7"; end
        if (kind == 3) begin tr = "R8"; tc = "R8"; tv = "R8"; tz = "R8"; tn = "R8"; end
        if (kind == 4) begin tr = "R9"; tc = "R9"; tv = "R9"; tz = "R9"; tn = "R9"; th = "R9"; end
        @(negedge clk);
        chk(tr, "res_hi", int'(hi), ehi);
        chk(tr, "res_lo", int'(lo), elo);
        chk(tc, "C", int'(fo[0]), ef & 1);
        chk(tv, "V", int'(fo[1]), (ef >> 1) & 1);
        chk(tz, "Z", int'(fo[2]), (ef >> 2) & 1);
        chk(tn, "N", int'(fo[3]), (ef >> 3) & 1);
        chk(th, "H", int'(fo[4]), (ef >> 4) & 1);
    endtask

    initial begin
        // reset-state / idle pattern: all-zero inputs (ADD 0+0 gives Z) R1 R2
        run(0, 0, 0, 0, 0);
        run(0, 8'h7F, 0, 8'h01, 0);      // R5 R6 R3: positive overflow with half carry
        run(0, 8'hFF, 0, 8'h01, 0);      // R4 R2: carry out, zero result
        run(1, 8'hFF, 0, 8'h00, 5'h01);  // R4: carry-in makes wrap
        run(2, 8'h00, 0, 8'h01, 5'h10);  // R4 R6: borrow, H held
        run(3, 8'h80, 0, 8'h00, 5'h01);  // R5: borrow-in gives signed overflow
        run(9, 8'h80, 8'h01, 0, 0);      // R5: A-B overflow
        run(8, 8'h08, 8'h08, 0, 0);      // R6: A+B half carry
        run(10, 8'h80, 0, 0, 0);         // R7: negate of most negative
        run(11, 0, 8'h00, 0, 5'h1F);     // R7: negate zero, no carry
        run(12, 0, 0, 8'h01, 0);         // R7: negate memory
        run(13, 8'hFF, 8'hFF, 0, 5'h1E); // R8: full product, flags held
        run(13, 8'h10, 8'h08, 0, 0);     // R8: C from product bit 7
        run(14, 8'h12, 8'h34, 8'h56, 5'h15); // R9
        run(15, 8'hAA, 8'h55, 8'hFF, 5'h0A); // R9
        for (int o = 0; o < 16; o++) begin
            for (int k = 0; k < 150; k++) begin
                run(o, int'($urandom_range(255)), int'($urandom_range(255)),
                    int'($urandom_range(255)), int'($urandom_range(31)));
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule